// File: doc/BRIEF.md
# Pin Interrupt Flag Controller

This block watches three external interrupt pins and turns activity on each one into a sticky request flag. Every channel is configured on its own to react either to a level or to an edge, with a polarity bit that picks active-high or rising when set and active-low or falling when clear. The pins are first brought into the clock domain through a short synchronizer chain, so they may be fully asynchronous.

Software reaches four word-sized registers over a simple synchronous bus: the flags, a wake-enable mask, the per-channel mode and the per-channel polarity. A flag is cleared by writing a one to its bit. In level mode that clear is refused while the pin still sits at its active level. Each flag drives its own interrupt request toward a downstream interrupt controller. A single wake-up request is raised when any flag whose wake enable is set is high. While a flag stays set, further activity on its pin leaves no separate trace, so software must clear the flag to see the next event.

Top module: `pin_irq_flagger`

## Requirements
- R1: While reset is held and right after it is released with all pins high, every register reads zero and `irqReq` and `wakeReq` are low.
- R2: Registers sit at byte offsets 0x0 (flags), 0x4 (wake enables), 0x8 (mode: 1 = edge, 0 = level) and 0xC (polarity: 1 = active-high or rising, 0 = active-low or falling). Bit n of each register belongs to channel n (n = 0..2). Wake, mode and polarity read back the value written. `busRdata` is combinational while `busSel` is high and `busWrite` is low, and is zero otherwise.
- R3: Register bits 31..3 always read zero, and writes to them are ignored.
- R4: In edge mode the selected edge on a pin sets that channel's flag, which is visible after the third rising clock edge following the pin change. The opposite edge sets nothing.
- R5: In level mode a pin held at its active level sets the flag, and a pin at its inactive level sets nothing.
- R6: `irqReq[n]` is high exactly when flag n is set.
- R7: Writing a one to a flag bit clears it (in edge mode, or in level mode with the pin inactive). Writing a zero to a flag bit leaves it unchanged.
- R8: In level mode a write-one clear does not take effect while the synchronized pin is at its active level.
- R9: While a flag is set, further trigger events on its pin are not recorded. After a clear, the flag stays low until a new event occurs.
- R10: If a trigger event and a write-one clear of the same channel meet in the same cycle, the flag ends up set.
- R11: `wakeReq` is high exactly when some channel has both its flag and its wake enable set.
- R12: Changing a channel's mode or polarity does not clear its flag. A later write-one clear works, subject to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 3 | External interrupt pins, asynchronous |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset; bits 3..2 pick the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no read is in progress |
| irqReq | output | 3 | Per-channel interrupt request (the flags) |
| wakeReq | output | 1 | Wake-up request |

## Verification
The main function is driven by a table of pin transitions under each mode and polarity combination. The table includes mixed rows where each channel has a different setting. The rising versus falling rows separate a correct polarity decode from an inverted one. The level rows with an inactive second value show that a level channel does not behave as an edge channel. Directed sequences then place an event and a clear in the same cycle, toggle a pin while its flag is already set, and change polarity over a set flag. These separate set priority, event blocking and configuration-independent flags from their plausible wrong variants.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned IRQ_CH = 3;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    REG_FLAG = 2'd0,
    REG_WAKE = 2'd1,
    REG_MODE = 2'd2,
    REG_POL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [IRQ_CH-1:0] clrMask;
    logic [IRQ_CH-1:0] edgeMode;
    logic [IRQ_CH-1:0] activeHigh;
  } ctrlStrobe_t;
endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [IRQ_CH-1:0]     flagVal,
  output logic [DATA_W-1:0]     busRdata,
  output logic [IRQ_CH-1:0]     wakeEn,
  output ctrlStrobe_t           strobe
);
  regSel_e regIdx;
  logic wrEn;
  logic rdEn;
  logic [IRQ_CH-1:0] modeQ;
  logic [IRQ_CH-1:0] polQ;
  logic [IRQ_CH-1:0] wakeQ;
  logic unusedBits;

  assign regIdx = regSel_e'(busAddr[WORD_LSB +: 2]);
  assign wrEn = busSel & busWrite;
  assign rdEn = busSel & ~busWrite;
  assign unusedBits = ^{busWdata[DATA_W-1:IRQ_CH], busAddr[WORD_LSB-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      polQ  <= '0;
      wakeQ <= '0;
    end else if (wrEn) begin
      case (regIdx)
        REG_WAKE: wakeQ <= busWdata[IRQ_CH-1:0];
        REG_MODE: modeQ <= busWdata[IRQ_CH-1:0];
        REG_POL:  polQ  <= busWdata[IRQ_CH-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    strobe.clrMask    = (wrEn && regIdx == REG_FLAG) ? busWdata[IRQ_CH-1:0] : '0;
    strobe.edgeMode   = modeQ;
    strobe.activeHigh = polQ;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (regIdx)
        REG_FLAG: busRdata[IRQ_CH-1:0] = flagVal;
        REG_WAKE: busRdata[IRQ_CH-1:0] = wakeQ;
        REG_MODE: busRdata[IRQ_CH-1:0] = modeQ;
        REG_POL:  busRdata[IRQ_CH-1:0] = polQ;
        default:  busRdata = '0;
      endcase
    end
  end

  assign wakeEn = wakeQ;
endmodule

// File: rtl/pin_irq_core.sv
module pin_irq_core
  import pin_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IRQ_CH-1:0] pinIn,
  input  ctrlStrobe_t       strobe,
  output logic [IRQ_CH-1:0] flagVal
);
  for (genvar ch = 0; ch < IRQ_CH; ch++) begin : gCh
    logic [SYNC_STAGES-1:0] shReg;
    logic syncQ;
    logic prevQ;
    logic flagBit;
    logic riseDet;
    logic fallDet;
    logic atActive;
    logic eventHit;
    logic clrOk;

    assign syncQ    = shReg[SYNC_STAGES-1];
    assign riseDet  = syncQ & ~prevQ;
    assign fallDet  = ~syncQ & prevQ;
    assign atActive = (syncQ == strobe.activeHigh[ch]);
    assign eventHit = strobe.edgeMode[ch]
                      ? (strobe.activeHigh[ch] ? riseDet : fallDet)
                      : atActive;
    // level channels refuse a clear while the pin is still active
    assign clrOk    = strobe.clrMask[ch] & (strobe.edgeMode[ch] | ~atActive);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg   <= '1;
        prevQ   <= 1'b1;
        flagBit <= 1'b0;
      end else begin
        shReg <= {shReg[SYNC_STAGES-2:0], pinIn[ch]};
        prevQ <= syncQ;
        if (eventHit)   flagBit <= 1'b1;
        else if (clrOk) flagBit <= 1'b0;
      end
    end

    assign flagVal[ch] = flagBit;
  end
endmodule

// File: rtl/pin_irq_flagger.sv
module pin_irq_flagger
  import pin_irq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IRQ_CH-1:0] pinIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [IRQ_CH-1:0] irqReq,
  output logic              wakeReq
);
  ctrlStrobe_t strobe;
  logic [IRQ_CH-1:0] flagVal;
  logic [IRQ_CH-1:0] wakeEn;

  pin_irq_regs #(.DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .flagVal(flagVal),
    .busRdata(busRdata), .wakeEn(wakeEn), .strobe(strobe)
  );

  pin_irq_core #(.SYNC_STAGES(SYNC_STAGES)) uCore (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobe(strobe), .flagVal(flagVal)
  );

  assign irqReq  = flagVal;
  assign wakeReq = |(flagVal & wakeEn);
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker
  import pin_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [IRQ_CH-1:0] irqReq,
  input logic              wakeReq
);
  // R7
  for (genvar i = 0; i < IRQ_CH; i++) begin : gDrop
    no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqReq[i]) |-> $past(busSel && busWrite && busAddr[3:2] == 2'd0 && busWdata[i]));
  end

  // R11
  wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (irqReq != '0));

  // R2
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> busRdata == '0);

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:IRQ_CH] == '0);
endmodule

bind pin_irq_flagger pin_irq_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .irqReq(irqReq), .wakeReq(wakeReq)
);

// File: tb/tb_pin_irq_flagger.sv
module tb_pin_irq_flagger;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] pinIn = 3'b111;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [2:0] irqReq;
  logic wakeReq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  localparam logic [3:0] A_FLAG = 4'h0, A_WAKE = 4'h4, A_MODE = 4'h8, A_POL = 4'hC;

  // fields: mode[14:12] pol[11:9] pinA[8:6] pinB[5:3] exp[2:0]
  localparam int VEC_N = 11;
  localparam logic [14:0] VECS [VEC_N] = '{
    {3'b111, 3'b111, 3'b000, 3'b111, 3'b111},  // rising edge
    {3'b111, 3'b111, 3'b111, 3'b000, 3'b000},  // falling under rising cfg
    {3'b111, 3'b000, 3'b111, 3'b000, 3'b111},  // falling edge
    {3'b111, 3'b000, 3'b000, 3'b111, 3'b000},  // rising under falling cfg
    {3'b000, 3'b111, 3'b000, 3'b111, 3'b111},  // level high active
    {3'b000, 3'b111, 3'b000, 3'b000, 3'b000},  // level high idle
    {3'b000, 3'b000, 3'b111, 3'b000, 3'b111},  // level low active
    {3'b000, 3'b000, 3'b111, 3'b111, 3'b000},  // level low idle
    {3'b011, 3'b101, 3'b010, 3'b101, 3'b111},  // mixed
    {3'b011, 3'b101, 3'b010, 3'b000, 3'b010},  // mixed
    {3'b100, 3'b001, 3'b110, 3'b011, 3'b101}   // mixed
  };

  pin_irq_flagger dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWdata = 0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic chkFlags(string tag, logic [2:0] exp);
    logic [31:0] d;
    regRead(A_FLAG, d);
    check(tag, d, {29'd0, exp});
    check(tag, {29'd0, irqReq}, {29'd0, exp});
  endtask

  initial begin
    logic [31:0] d;
    tick(3);
    check("R1 irq in reset", {29'd0, irqReq}, 32'd0);
    check("R1 wake in reset", {31'd0, wakeReq}, 32'd0);
    rstN = 1;
    tick(4);
    chkFlags("R1 flags after reset", 3'b000);
    regRead(A_WAKE, d); check("R1 wake reg", d, 0);
    regRead(A_MODE, d); check("R1 mode reg", d, 0);
    regRead(A_POL, d);  check("R1 pol reg", d, 0);
    check("R1 wake out", {31'd0, wakeReq}, 0);
    check("R2 idle rdata", busRdata, 0);

    // R2 / R3 map and unused bits
    regWrite(A_WAKE, 32'h5);
    regWrite(A_MODE, 32'h3);
    regWrite(A_POL, 32'h6);
    regRead(A_WAKE, d); check("R2 wake readback", d, 32'h5);
    regRead(A_MODE, d); check("R2 mode readback", d, 32'h3);
    regRead(A_POL, d);  check("R2 pol readback", d, 32'h6);
    regWrite(A_MODE, 32'hFFFF_FFF8);
    regRead(A_MODE, d); check("R3 upper ignored", d, 32'h0);
    regWrite(A_WAKE, 32'hFFFF_FFFF);
    regRead(A_WAKE, d); check("R3 upper zero", d, 32'h7);
    regWrite(A_WAKE, 32'h0);

    // R4 R5 R6 table
    for (int i = 0; i < VEC_N; i++) begin
      regWrite(A_MODE, {29'd0, VECS[i][14:12]});
      regWrite(A_POL,  {29'd0, VECS[i][11:9]});
      pinIn = VECS[i][8:6];
      tick(5);
      regWrite(A_FLAG, 32'h7);
      tick(1);
      chkFlags($sformatf("R4/R5 vec %0d pre", i), 3'b000);
      pinIn = VECS[i][5:3];
      tick(4);
      chkFlags($sformatf("R4 R5 R6 vec %0d", i), VECS[i][2:0]);
    end

    // R7 write-one-clear, zero no effect
    regWrite(A_MODE, 32'h7);
    regWrite(A_POL, 32'h7);
    pinIn = 3'b000; tick(5);
    regWrite(A_FLAG, 32'h7);
    pinIn = 3'b111; tick(4);
    chkFlags("R7 all set", 3'b111);
    regWrite(A_FLAG, 32'h2);
    chkFlags("R7 clear ch1", 3'b101);
    regWrite(A_FLAG, 32'h0);
    chkFlags("R7 zero write", 3'b101);

    // R9 event blocked while set, no memory after clear
    pinIn = 3'b110; tick(4);
    pinIn = 3'b111; tick(4);
    chkFlags("R9 still set", 3'b101);
    regWrite(A_FLAG, 32'h5);
    tick(4);
    chkFlags("R9 no stored event", 3'b000);

    // R10 set beats simultaneous clear
    pinIn = 3'b000; tick(5);
    regWrite(A_FLAG, 32'h7);
    pinIn = 3'b001;
    tick(2);
    busSel = 1; busWrite = 1; busAddr = A_FLAG; busWdata = 32'h1;
    tick(1);
    busSel = 0; busWrite = 0; busWdata = 0;
    chkFlags("R10 set wins", 3'b001);
    regWrite(A_FLAG, 32'h1);
    chkFlags("R7 later clear", 3'b000);

    // R8 level clear gated by pin
    regWrite(A_MODE, 32'h0);
    regWrite(A_POL, 32'h7);
    pinIn = 3'b001; tick(4);
    chkFlags("R5 level set", 3'b001);
    regWrite(A_FLAG, 32'h7);
    chkFlags("R8 clear refused", 3'b001);
    pinIn = 3'b000; tick(4);
    chkFlags("R8 still set after release", 3'b001);
    regWrite(A_FLAG, 32'h7);
    chkFlags("R8 clear accepted", 3'b000);

    // R12 config change keeps flag
    regWrite(A_POL, 32'h0);
    tick(2);
    chkFlags("R12 spurious set", 3'b111);
    regWrite(A_POL, 32'h7);
    tick(2);
    chkFlags("R12 pol change keeps", 3'b111);
    regWrite(A_FLAG, 32'h7);
    chkFlags("R12 clear after change", 3'b000);
    pinIn = 3'b111; tick(4);
    regWrite(A_MODE, 32'h7);
    chkFlags("R12 mode change keeps", 3'b111);
    regWrite(A_FLAG, 32'h7);
    chkFlags("R12 edge clear", 3'b000);

    // R11 wake gating
    pinIn = 3'b000; tick(5);
    regWrite(A_FLAG, 32'h7);
    regWrite(A_WAKE, 32'h4);
    pinIn = 3'b001; tick(4);
    check("R11 masked channel", {31'd0, wakeReq}, 0);
    pinIn = 3'b101; tick(4);
    check("R11 enabled channel", {31'd0, wakeReq}, 1);
    regWrite(A_FLAG, 32'h4);
    check("R11 wake drops", {31'd0, wakeReq}, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule